// File: doc/BRIEF.md
# Tone Validation Guard Timer

This block qualifies a raw tone-detect flag before anything downstream trusts it. The flag from a dual-tone detector is high whenever a tone pair is currently seen, and it can chatter. The block raises a validated output only after the raw flag has stayed high for a tone-present guard period. Once the output is high, it drops only after the raw flag has stayed low for a separate tone-absent guard period. Short bursts are therefore rejected, and short dropouts inside a digit are bridged.

Time is measured in ticks from a prescaler on the system clock. A 4.194304 MHz clock divided by 4096 gives ticks of about 0.977 ms, and the default guard of 30 ticks sits between the 20 ms reject bound and the 40 ms accept bound. A powerdown input forces the output low and clears all timing state. A single-cycle pulse marks every rising edge of the validated output, so that a serial readout stage can re-arm.

Top module: `tvg_guard_timer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, tone_valid_o and tone_rise_o are 0.
- R2: With pwdn_i low, tone_valid_o stays 0 for at least (PRESENT_TICKS-1)*TICK_DIV cycles after tone_raw_i rises. If tone_raw_i stays high, tone_valid_o is 1 within PRESENT_TICKS*TICK_DIV+4 cycles.
- R3: A high pulse on tone_raw_i shorter than (PRESENT_TICKS-1)*TICK_DIV cycles never sets tone_valid_o.
- R4: While tone_valid_o is 1, a low gap on tone_raw_i shorter than (ABSENT_TICKS-1)*TICK_DIV cycles leaves tone_valid_o at 1 throughout.
- R5: After tone_valid_o is 1, a fall of tone_raw_i that lasts keeps tone_valid_o at 1 for at least (ABSENT_TICKS-1)*TICK_DIV cycles. tone_valid_o is 0 within ABSENT_TICKS*TICK_DIV+4 cycles.
- R6: A low cycle on tone_raw_i during the present guard restarts that guard. Several high segments, each shorter than the R3 bound, never set tone_valid_o.
- R7: One cycle after pwdn_i is sampled high, tone_valid_o is 0, and it stays 0 while pwdn_i is high. After pwdn_i falls, a full present guard (R2) is needed again.
- R8: tone_rise_o is high for exactly one cycle, coinciding with the first cycle of each rise of tone_valid_o, and is 0 at all other times.
- R9: The return of tone_raw_i clears the absent count. Two separate low gaps, each within the R4 bound but together longer than it, do not drop tone_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwdn_i | input | 1 | Powerdown: forces the output low and clears timing state |
| tone_raw_i | input | 1 | Unqualified tone-present flag, asynchronous |
| tone_valid_o | output | 1 | Validated tone-present output |
| tone_rise_o | output | 1 | One-cycle pulse on each rise of tone_valid_o |

## Verification
Powerdown and completion of the present guard can fall in the same cycle. Powerdown must win, and no rise pulse may escape. To provoke this, the bench keeps tone_raw_i high and holds pwdn_i across the whole window in which acceptance would otherwise occur. It then judges that tone_valid_o and tone_rise_o stay low throughout that window. After release, tone_valid_o must again wait a full present guard before it rises, which shows that the count was discarded rather than frozen.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } tvg_state_e;
endpackage

// File: rtl/tvg_sync.sv
module tvg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tvg_tick.sv
module tvg_tick #(
  parameter int TICK_DIV = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !clr_i;
endmodule

// File: rtl/tvg_guard.sv
module tvg_guard
  import tvg_pkg::*;
#(
  parameter int PRESENT_TICKS = 30,
  parameter int ABSENT_TICKS  = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwdn_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic valid_o,
  output logic rise_o
);
  localparam int MAXT = (PRESENT_TICKS > ABSENT_TICKS) ? PRESENT_TICKS : ABSENT_TICKS;
  localparam int GW   = $clog2(MAXT + 1);
  localparam logic [GW-1:0] P_LAST = GW'(PRESENT_TICKS - 1);
  localparam logic [GW-1:0] A_LAST = GW'(ABSENT_TICKS - 1);

  tvg_state_e    state_q;
  logic [GW-1:0] cnt_q;
  logic          rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rise_q  <= 1'b0;
    end else if (pwdn_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!raw_i) cnt_q <= '0;        // present guard restarts on any gap
          else if (tick_i) begin
            if (cnt_q == P_LAST) begin
              state_q <= ST_ACTIVE;
              cnt_q   <= '0;
              rise_q  <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (raw_i) cnt_q <= '0;         // tone back: dropout bridged
          else if (tick_i) begin
            if (cnt_q == A_LAST) begin
              state_q <= ST_IDLE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign valid_o = (state_q == ST_ACTIVE);
  assign rise_o  = rise_q;
endmodule

// File: rtl/tvg_guard_timer.sv
module tvg_guard_timer #(
  parameter int TICK_DIV      = 4096,
  parameter int PRESENT_TICKS = 30,
  parameter int ABSENT_TICKS  = 30,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwdn_i,
  input  logic tone_raw_i,
  output logic tone_valid_o,
  output logic tone_rise_o
);
  logic raw_sync;
  logic tick;

  tvg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tone_raw_i),
    .q_o   (raw_sync)
  );

  tvg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pwdn_i),
    .tick_o(tick)
  );

  tvg_guard #(
    .PRESENT_TICKS(PRESENT_TICKS),
    .ABSENT_TICKS (ABSENT_TICKS)
  ) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwdn_i (pwdn_i),
    .tick_i (tick),
    .raw_i  (raw_sync),
    .valid_o(tone_valid_o),
    .rise_o (tone_rise_o)
  );
endmodule

// File: rtl/tvg_guard_timer_chk.sv
module tvg_guard_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwdn_i,
  input logic raw_sync,
  input logic tone_valid_o,
  input logic tone_rise_o
);
  p_pwdn_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |=> !tone_valid_o);

  p_rise_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tone_valid_o) |-> tone_rise_o);

  p_rise_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_rise_o |=> !tone_rise_o);

  p_rise_has_tone_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tone_valid_o) |-> $past(raw_sync) && !$past(pwdn_i));

  p_hold_while_tone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_valid_o && raw_sync && !pwdn_i) |=> tone_valid_o);

  p_fall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tone_valid_o) |-> ($past(pwdn_i) || !$past(raw_sync)));
endmodule

bind tvg_guard_timer tvg_guard_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwdn_i      (pwdn_i),
  .raw_sync    (raw_sync),
  .tone_valid_o(tone_valid_o),
  .tone_rise_o (tone_rise_o)
);

// File: tb/tb_tvg_guard_timer.sv
module tb_tvg_guard_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int PT  = 5;
  localparam int AT  = 5;
  localparam int EARLY = (PT - 1) * DIV - 2;  // must still be low/high here
  localparam int LATE  = PT * DIV + 10;       // must have switched by here

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwdn = 1'b0;
  logic raw = 1'b0;
  logic valid, rise;
  int   n_run = 0, n_fail = 0, rise_cnt = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tvg_guard_timer #(
    .TICK_DIV(DIV), .PRESENT_TICKS(PT), .ABSENT_TICKS(AT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwdn_i(pwdn),
    .tone_raw_i(raw), .tone_valid_o(valid), .tone_rise_o(rise)
  );

  always @(negedge clk) if (rise) rise_cnt++;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // count cycles over n where valid != exp
  task automatic hold(string req, int n, logic exp);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid != exp) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic accept_tone();
    raw = 1'b1;
    cyc(LATE);
  endtask

  task automatic release_tone();
    raw = 1'b0;
    cyc(LATE);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 valid in reset", valid, 0);
    chk("R1 rise in reset", rise, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 valid after reset", valid, 0);
    chk("R1 rise after reset", rise, 0);
  endtask

  task automatic t_accept();
    int r0 = rise_cnt;
    raw = 1'b1;
    hold("R2 low before guard", EARLY, 1'b0);
    cyc(LATE - EARLY);
    chk("R2 high after guard", valid, 1);
    chk("R8 one rise pulse", rise_cnt - r0, 1);
    chk("R8 rise not stuck", rise, 0);
    raw = 1'b0;
    hold("R5 held during absent guard", (AT - 1) * DIV - 2, 1'b1);
    cyc(AT * DIV + 10 - ((AT - 1) * DIV - 2));
    chk("R5 low after absent guard", valid, 0);
    chk("R8 no pulse on fall", rise_cnt - r0, 1);
  endtask

  task automatic t_short_burst();
    int r0 = rise_cnt;
    raw = 1'b1;
    cyc((PT - 1) * DIV - 4);
    raw = 1'b0;
    hold("R3 short burst rejected", 40, 1'b0);
    chk("R3 no rise pulse", rise_cnt - r0, 0);
  endtask

  task automatic t_restart();
    int r0 = rise_cnt;
    for (int k = 0; k < 3; k++) begin
      raw = 1'b1;
      cyc((PT - 1) * DIV - 4);
      raw = 1'b0;
      cyc(3);
    end
    hold("R6 segmented burst rejected", 40, 1'b0);
    chk("R6 no rise pulse", rise_cnt - r0, 0);
  endtask

  task automatic t_bridge();
    int r0;
    accept_tone();
    chk("R4 setup high", valid, 1);
    r0 = rise_cnt;
    raw = 1'b0;
    hold("R4 first dropout bridged", (AT - 1) * DIV - 4, 1'b1);
    raw = 1'b1;
    hold("R9 high between dropouts", 6, 1'b1);
    raw = 1'b0;
    hold("R9 second dropout bridged", (AT - 1) * DIV - 4, 1'b1);
    raw = 1'b1;
    hold("R9 still high after return", 20, 1'b1);
    chk("R4 no extra rise", rise_cnt - r0, 0);
    release_tone();
    chk("R5 low after release", valid, 0);
  endtask

  task automatic t_pwdn();
    int r0;
    accept_tone();
    chk("R7 setup high", valid, 1);
    pwdn = 1'b1;
    cyc(1);
    chk("R7 forced low", valid, 0);
    // raw stays high: present guard would complete inside this window
    r0 = rise_cnt;
    hold("R7 low during powerdown", 2 * LATE, 1'b0);
    chk("R7 no rise in powerdown", rise_cnt - r0, 0);
    pwdn = 1'b0;
    hold("R7 full guard after release", EARLY, 1'b0);
    cyc(LATE - EARLY);
    chk("R7 high after regained guard", valid, 1);
    chk("R8 pulse after powerdown", rise_cnt - r0, 1);
    release_tone();
  endtask

  task automatic t_two_digits();
    int r0 = rise_cnt;
    accept_tone();
    release_tone();
    chk("R5 gap between digits", valid, 0);
    accept_tone();
    chk("R2 second digit", valid, 1);
    chk("R8 two pulses", rise_cnt - r0, 2);
    release_tone();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_accept();
    t_short_burst();
    t_restart();
    t_bridge();
    t_pwdn();
    t_two_digits();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule